// File: doc/BRIEF.md
# USB Device Interrupt Status and Control Registers

This block is the interrupt and control register set of a low-speed USB device interface. A status byte collects one-cycle event strobes from the serial bus engine: correct transfer, transfer error, bus activity during suspend, bus reset, keep-alive strobe and end of resume. Software clears these flags by writing zeros. A mask byte chooses which flags may raise the combined interrupt request. A control nibble drives resume signalling, regulator power-down, suspend entry and a software-held interface reset.

Firmware reaches the registers through a small synchronous port with a 2-bit address and a registered read path. Status flags are cleared with one store: each zero clears its bit and each one keeps it, so no read-modify-write is needed. The block also raises a wakeup request when bus activity ends suspend. It asserts a clear strobe for the device-address and endpoint registers while a bus reset or a forced reset is active.

Top module: `usb_irq_regs`

## Requirements
- R1: After the synchronous reset the status byte (address 0) reads 00h, the mask byte (address 1) reads 00h and the control byte (address 2) reads 06h. So `regulator_off` and `suspend_mode` are 1, and `resume_drv`, `intf_reset` and `irq_req` are 0.
- R2: Each event strobe sets its status flag at the next clock edge. The flag positions are: `ev_susp` bit 7, `ev_dovr` bit 6, `ev_ctr` bit 5, `ev_err` bit 4, bus reset bit 1.
- R3: A write to address 0 clears every status bit whose data bit is 0 and leaves unchanged every bit whose data bit is 1.
- R4: When a hardware event and a software clear hit the same status flag in the same cycle, the flag ends set.
- R5: Status bit 3 (overrun) sets when an error strobe arrives while bit 4 is still set, or when a start-of-frame source arrives while bit 0 is still set. A repeated correct-transfer strobe does not set it.
- R6: A `bus_wake` strobe sets status bit 2 only while control bit 1 (suspend) is 1, and it clears control bit 1 at the same edge. Outside suspend it changes neither register. `wake_req` follows status bit 2.
- R7: Status bit 0 sets on either `ev_sof` (keep-alive) or `ev_rsm_end` (end of resume sequence).
- R8: `irq_req` is 1 exactly when some status bit and the same mask bit are both 1 and `irq_dis` is 0.
- R9: Control bits 7:4 always read 0. Bit 3 drives `resume_drv`, bit 2 `regulator_off`, bit 1 `suspend_mode` and bit 0 `intf_reset`.
- R10: When a write to address 2 changes control bit 0 from 1 to 0, status bit 1 sets at that edge.
- R11: `ep_clear` is 1 while `ev_busrst` is high or control bit 0 is 1, and 0 otherwise.
- R12: `bus_rdata` shows the register selected by `bus_addr` one clock edge after the address is presented. Address 3 reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 status, 1 mask, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ev_susp | input | 1 | Suspend event strobe |
| ev_dovr | input | 1 | DMA overrun event strobe |
| ev_ctr | input | 1 | Correct transfer event strobe |
| ev_err | input | 1 | Transfer error event strobe |
| bus_wake | input | 1 | Bus activity seen strobe |
| ev_busrst | input | 1 | Bus reset detected strobe |
| ev_sof | input | 1 | Keep-alive / start-of-frame strobe |
| ev_rsm_end | input | 1 | End of resume sequence strobe |
| irq_dis | input | 1 | Global interrupt disable |
| irq_req | output | 1 | Combined interrupt request |
| wake_req | output | 1 | Wakeup request |
| resume_drv | output | 1 | Drive resume signalling on the bus |
| regulator_off | output | 1 | Turn the transceiver regulator off |
| suspend_mode | output | 1 | Interface is in suspend |
| intf_reset | output | 1 | Interface held in reset by software |
| ep_clear | output | 1 | Return address and endpoint registers to reset values |

## Verification
Status, mask and control state changes at the first rising edge after a strobe or write. `bus_rdata` needs one more edge after the address is presented. `irq_req`, `wake_req`, `ep_clear` and the control outputs follow the registers and inputs without an extra edge. The bench changes inputs on the falling edge and reads registered results at the next falling edge, half a period after they settle. Combinational outputs such as `ep_clear` during a bus-reset strobe, or `irq_req` under `irq_dis`, are read 1 ns after the input changes, inside the same cycle.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int CTL_W  = 4;

    localparam int B_SUSP  = 7;
    localparam int B_DOVR  = 6;
    localparam int B_CTR   = 5;
    localparam int B_ERR   = 4;
    localparam int B_IOVR  = 3;
    localparam int B_ESUSP = 2;
    localparam int B_RST   = 1;
    localparam int B_SOF   = 0;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STAT = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic resume;
        logic pdwn;
        logic fsusp;
        logic fres;
    } ctl_t;

    localparam ctl_t CTL_RST = '{resume: 1'b0, pdwn: 1'b1, fsusp: 1'b1, fres: 1'b0};

    typedef struct packed {
        logic susp;
        logic dovr;
        logic ctr;
        logic err;
        logic wake;
        logic busrst;
        logic sof;
        logic rsm_end;
    } ev_t;

    function automatic logic [REG_W-1:0] ctl_byte(input ctl_t c);
        return {{(REG_W-CTL_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/usbirq_status.sv
module usbirq_status
    import usbirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ev_t              ev,
    input  logic             in_suspend,
    input  logic             fres_release,
    input  logic             wr_clr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] istr
);
    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] kept;
    logic             sof_any;

    always_comb begin
        sof_any        = ev.sof | ev.rsm_end;
        set_v          = '0;
        set_v[B_SUSP]  = ev.susp;
        set_v[B_DOVR]  = ev.dovr;
        set_v[B_CTR]   = ev.ctr;
        set_v[B_ERR]   = ev.err;
        set_v[B_IOVR]  = (ev.err & istr[B_ERR]) | (sof_any & istr[B_SOF]);
        set_v[B_ESUSP] = ev.wake & in_suspend;
        set_v[B_RST]   = ev.busrst | fres_release;
        set_v[B_SOF]   = sof_any;
        kept           = wr_clr ? (istr & wdata) : istr;
    end

    always_ff @(posedge clk) begin
        if (rst) istr <= '0;
        else     istr <= kept | set_v;
    end
endmodule

// File: rtl/usbirq_ctrl.sv
module usbirq_ctrl
    import usbirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_mask,
    input  logic             wr_ctl,
    input  logic [REG_W-1:0] wdata,
    input  logic             bus_activity,
    output logic [REG_W-1:0] imr,
    output ctl_t             ctl,
    output logic             fres_release
);
    ctl_t ctl_nx;

    assign fres_release = wr_ctl & ctl.fres & ~wdata[0];

    always_comb begin
        ctl_nx = ctl;
        if (wr_ctl) ctl_nx = ctl_t'(wdata[CTL_W-1:0]);
        if (bus_activity) ctl_nx.fsusp = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            imr <= '0;
            ctl <= CTL_RST;
        end else begin
            if (wr_mask) imr <= wdata;
            ctl <= ctl_nx;
        end
    end
endmodule

// File: rtl/usbirq_rdmux.sv
module usbirq_rdmux
    import usbirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  istr,
    input  logic [REG_W-1:0]  imr,
    input  ctl_t              ctl,
    output logic [REG_W-1:0]  rdata
);
    logic [REG_W-1:0] sel;

    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_STAT: sel = istr;
            SEL_MASK: sel = imr;
            SEL_CTL:  sel = ctl_byte(ctl);
            default:  sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= sel;
    end
endmodule

// File: rtl/usb_irq_regs.sv
module usb_irq_regs
    import usbirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ev_susp,
    input  logic       ev_dovr,
    input  logic       ev_ctr,
    input  logic       ev_err,
    input  logic       bus_wake,
    input  logic       ev_busrst,
    input  logic       ev_sof,
    input  logic       ev_rsm_end,
    input  logic       irq_dis,
    output logic       irq_req,
    output logic       wake_req,
    output logic       resume_drv,
    output logic       regulator_off,
    output logic       suspend_mode,
    output logic       intf_reset,
    output logic       ep_clear
);
    ev_t              ev;
    ctl_t             ctl_q;
    logic [REG_W-1:0] istr_q;
    logic [REG_W-1:0] imr_q;
    logic             fres_rel;
    logic             wr_stat, wr_mask, wr_ctl;

    assign ev = '{susp: ev_susp, dovr: ev_dovr, ctr: ev_ctr, err: ev_err,
                  wake: bus_wake, busrst: ev_busrst, sof: ev_sof,
                  rsm_end: ev_rsm_end};

    assign wr_stat = bus_wr & (reg_sel_e'(bus_addr) == SEL_STAT);
    assign wr_mask = bus_wr & (reg_sel_e'(bus_addr) == SEL_MASK);
    assign wr_ctl  = bus_wr & (reg_sel_e'(bus_addr) == SEL_CTL);

    usbirq_status u_stat (
        .clk(clk), .rst(rst), .ev(ev), .in_suspend(ctl_q.fsusp),
        .fres_release(fres_rel), .wr_clr(wr_stat), .wdata(bus_wdata),
        .istr(istr_q)
    );

    usbirq_ctrl u_ctl (
        .clk(clk), .rst(rst), .wr_mask(wr_mask), .wr_ctl(wr_ctl),
        .wdata(bus_wdata), .bus_activity(bus_wake), .imr(imr_q),
        .ctl(ctl_q), .fres_release(fres_rel)
    );

    usbirq_rdmux u_rd (
        .clk(clk), .rst(rst), .addr(bus_addr), .istr(istr_q),
        .imr(imr_q), .ctl(ctl_q), .rdata(bus_rdata)
    );

    assign irq_req       = (|(istr_q & imr_q)) & ~irq_dis;
    assign wake_req      = istr_q[B_ESUSP];
    assign resume_drv    = ctl_q.resume;
    assign regulator_off = ctl_q.pdwn;
    assign suspend_mode  = ctl_q.fsusp;
    assign intf_reset    = ctl_q.fres;
    assign ep_clear      = ev_busrst | ctl_q.fres;
endmodule

// File: rtl/usb_irq_regs_chk.sv
module usb_irq_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       ev_ctr,
    input logic       ev_err,
    input logic       bus_wake,
    input logic       irq_dis,
    input logic       irq_req,
    input logic       suspend_mode,
    input logic       intf_reset,
    input logic [7:0] istr
);
    // R2
    ctr_set_chk: assert property (@(posedge clk) disable iff (rst)
        ev_ctr |=> istr[5]);

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (istr[5] && !(bus_wr && bus_addr == 2'd0 && !bus_wdata[5])) |=> istr[5]);

    // R5
    err_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_err && istr[4]) |=> istr[3]);

    // R6
    wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wake |=> !suspend_mode);

    // R6
    wake_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wake && !suspend_mode && !istr[2]) |=> !istr[2]);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_dis |-> !irq_req);

    // R10
    fres_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(intf_reset) |-> istr[1]);

    // R9
    ctl_upper_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_addr) == 2'd2) |-> (bus_rdata[7:4] == 4'h0));
endmodule

bind usb_irq_regs usb_irq_regs_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_ctr(ev_ctr),
    .ev_err(ev_err), .bus_wake(bus_wake), .irq_dis(irq_dis),
    .irq_req(irq_req), .suspend_mode(suspend_mode),
    .intf_reset(intf_reset), .istr(istr_q)
);

// File: tb/sim_usb_irq_regs.sv
`timescale 1ns/1ps
module sim_usb_irq_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic ev_susp = 0, ev_dovr = 0, ev_ctr = 0, ev_err = 0;
    logic bus_wake = 0, ev_busrst = 0, ev_sof = 0, ev_rsm_end = 0;
    logic irq_dis = 1'b0;
    logic irq_req, wake_req, resume_drv, regulator_off, suspend_mode, intf_reset, ep_clear;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    usb_irq_regs u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_susp(ev_susp),
        .ev_dovr(ev_dovr), .ev_ctr(ev_ctr), .ev_err(ev_err),
        .bus_wake(bus_wake), .ev_busrst(ev_busrst), .ev_sof(ev_sof),
        .ev_rsm_end(ev_rsm_end), .irq_dis(irq_dis), .irq_req(irq_req),
        .wake_req(wake_req), .resume_drv(resume_drv),
        .regulator_off(regulator_off), .suspend_mode(suspend_mode),
        .intf_reset(intf_reset), .ep_clear(ep_clear)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    // bit order: susp dovr ctr err wake busrst sof rsm_end
    task automatic pulse(input logic [7:0] e);
        {ev_susp, ev_dovr, ev_ctr, ev_err, bus_wake, ev_busrst, ev_sof, ev_rsm_end} = e;
        @(negedge clk);
        {ev_susp, ev_dovr, ev_ctr, ev_err, bus_wake, ev_busrst, ev_sof, ev_rsm_end} = 8'h00;
    endtask

    task automatic fill_all();
        wr(2'd2, 8'h02);
        pulse(8'hFF);
        pulse(8'h10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] exp_bits [6];
        logic [7:0] ev_bits [6];
        ev_bits  = '{8'h80, 8'h40, 8'h20, 8'h10, 8'h04, 8'h02};
        exp_bits = '{8'h80, 8'h40, 8'h20, 8'h10, 8'h02, 8'h01};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, d); chk("R1 status", d, 8'h00);
        rd(2'd1, d); chk("R1 mask", d, 8'h00);
        rd(2'd2, d); chk("R1 control", d, 8'h06);
        chk("R1 outputs", {1'b0, irq_req, wake_req, resume_drv, regulator_off,
                           suspend_mode, intf_reset, 1'b0}, 8'h0C);

        // R2 single event flags
        wr(2'd2, 8'h00);
        for (int k = 0; k < 6; k++) begin
            wr(2'd0, 8'h00);
            pulse(ev_bits[k]);
            rd(2'd0, d); chk("R2 event flag", d, exp_bits[k]);
        end

        // R7 end of resume sets SOF flag
        wr(2'd0, 8'h00);
        pulse(8'h01);
        rd(2'd0, d); chk("R7 resume end", d, 8'h01);

        // R5 overrun
        wr(2'd0, 8'h00); pulse(8'h10); pulse(8'h10);
        rd(2'd0, d); chk("R5 err twice", d, 8'h18);
        wr(2'd0, 8'h00); pulse(8'h02); pulse(8'h01);
        rd(2'd0, d); chk("R5 sof then resume end", d, 8'h09);
        wr(2'd0, 8'h00); pulse(8'h20); pulse(8'h20);
        rd(2'd0, d); chk("R5 ctr twice", d, 8'h20);

        // R6 wake outside suspend is ignored
        wr(2'd0, 8'h00); wr(2'd2, 8'h00);
        pulse(8'h08);
        rd(2'd0, d); chk("R6 wake ignored status", d, 8'h00);
        rd(2'd2, d); chk("R6 wake ignored control", d, 8'h00);
        // R6 wake in suspend
        wr(2'd2, 8'h02);
        chk("R6 suspend entered", {7'd0, suspend_mode}, 8'h01);
        pulse(8'h08);
        rd(2'd0, d); chk("R6 esusp flag", d, 8'h04);
        chk("R6 wake_req", {7'd0, wake_req}, 8'h01);
        chk("R6 suspend left", {7'd0, suspend_mode}, 8'h00);

        // R3 write-zero sweep
        for (int p = 0; p < 256; p++) begin
            fill_all();
            wr(2'd0, p[7:0]);
            rd(2'd0, d); chk("R3 clear pattern", d, p[7:0]);
        end

        // R4 set wins over clear
        wr(2'd0, 8'h00);
        ev_ctr = 1'b1; ev_sof = 1'b1;
        wr(2'd0, 8'h00);
        ev_ctr = 1'b0; ev_sof = 1'b0;
        rd(2'd0, d); chk("R4 set wins", d, 8'h21);

        // R8 mask sweep
        fill_all();
        wr(2'd0, 8'h5A);
        for (int m = 0; m < 256; m++) begin
            wr(2'd1, m[7:0]);
            chk("R8 irq", {7'd0, irq_req}, {7'd0, |(8'h5A & m[7:0])});
            irq_dis = 1'b1; #1;
            chk("R8 irq disabled", {7'd0, irq_req}, 8'h00);
            irq_dis = 1'b0;
        end

        // R12 read latency and unused address
        wr(2'd1, 8'h3C);
        bus_addr = 2'd1; @(posedge clk); #1;
        bus_addr = 2'd3; @(negedge clk);
        chk("R12 latency", bus_rdata, 8'h3C);
        @(negedge clk);
        chk("R12 addr3", bus_rdata, 8'h00);

        // R11 bus reset strobe
        wr(2'd2, 8'h00);
        chk("R11 idle", {7'd0, ep_clear}, 8'h00);
        ev_busrst = 1'b1; #1;
        chk("R11 busrst", {7'd0, ep_clear}, 8'h01);
        @(negedge clk); ev_busrst = 1'b0;

        // R9 control outputs and upper bits
        wr(2'd0, 8'h00);
        wr(2'd2, 8'hFF);
        rd(2'd2, d); chk("R9 control read", d, 8'h0F);
        chk("R9 outputs", {4'd0, resume_drv, regulator_off, suspend_mode, intf_reset}, 8'h0F);
        chk("R11 forced reset", {7'd0, ep_clear}, 8'h01);
        wr(2'd2, 8'h0A);
        chk("R9 outputs b", {4'd0, resume_drv, regulator_off, suspend_mode, intf_reset}, 8'h0A);

        // R10 releasing forced reset sets reset flag
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h01);
        rd(2'd0, d); chk("R10 hold no flag", d, 8'h00);
        wr(2'd2, 8'h00);
        rd(2'd0, d); chk("R10 release flag", d, 8'h02);
        chk("R11 released", {7'd0, ep_clear}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule